// File: doc/BRIEF.md
# NAND ECC engine control registers

This block is the memory-mapped control and status front end of a NAND flash error-correction engine. It has two channels, one encoder and one decoder. A simple 32-bit register bus reaches both. Each channel has the following registers:

- a start/stop control word;
- a packed configuration word;
- an idle flag;
- an interrupt enable word;
- a status word that clears when it is read;
- a per-sector completion bitmap.

One interrupt output combines the enabled status bits of the two channels.

The correction arithmetic is not part of this block. A parameterised busy timer takes its place. It holds a channel busy for `STEP_CYC` cycles per sector across `SECTORS` sectors and marks each sector done as it ends. When the encoder finishes a page, a parity readout window becomes valid. The window's length follows the strength index in the encoder configuration. Its words hold a fixed, computed pattern, so that software can exercise the parity copy path.

The bus is a single-cycle strobe interface. Read data is combinational from `addr_i` while `req_i` is high and `we_i` is low. Read side effects take place at the closing clock edge.

Top module: `nand_ecc_regs`

## Requirements
- R1: After reset, both control bits read 0. Both idle registers read 1 in bit 0. Configuration, enable, status and bitmap registers read 0, and `irq_o` is 0.
- R2: A write with bit 0 = 1 to a control register (encoder 0x000, decoder 0x100) starts that channel, restarting it if it is already running. Bit 0 of its idle register (encoder 0x00C, decoder 0x10C) reads 0 until `SECTORS*STEP_CYC` cycles have passed, and then reads 1 again.
- R3: Bit s of a channel's done bitmap (decoder 0x124, encoder 0x088) sets when sector s ends. Sectors end in order, every `STEP_CYC` cycles. A start clears the whole bitmap.
- R4: With enable bit 1 clear, the status bit 0 (encoder 0x084, decoder 0x204) sets at the end of every sector. A read of the status register returns the bit and then clears it. When a set and a read fall in the same cycle, the set wins.
- R5: When `PAGE_IRQ` is 1, setting enable bit 1 makes status set only when the last sector of the page ends.
- R6: `irq_o` is high whenever a channel's status bit and its enable bit 0 are both 1. The enable registers are at encoder 0x080 and decoder 0x200.
- R7: A write with bit 0 = 0 to a control register stops the channel. Idle reads 1 from the next cycle, the channel's status clears, and its bitmap stops changing.
- R8: Configuration words (encoder 0x004, decoder 0x104) read back exactly as written. A write made while that channel is busy is ignored.
- R9: Parity word i reads at 0x010 + 4i and is valid once an encoder page has completed.
  - A valid word reads `PAR_SEED ^ {4{i[7:0]}}`. It is valid when i < ceil(strength*`PAR_BITS`/32), where the strength comes from encoder configuration bits 4:0 = k.
  - The strength is 4+2k for k≤10, 28+4(k−11) for 11≤k<`NUM_STR`, and 0 beyond that.
  - Words that are not valid read 0.
  - An encoder start clears the window.
- R10: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is the middle of a page. At that point some sectors are done and others are not, so per-step and per-page interrupt behaviour can be told apart.

The bench starts a decode and then polls the done bitmap in two-cycle reads. It stops at the first sector bit, which is well before the second sector ends. There it samples `irq_o` and the status in both interrupt modes. It also stops a run halfway through, to confirm that idle, status and the bitmap freeze.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_ENC_CTL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_ENC_CFG  = 12'h004;
  localparam logic [ADDR_W-1:0] A_ENC_IDLE = 12'h00C;
  localparam logic [ADDR_W-1:0] A_PAR_BASE = 12'h010;
  localparam logic [ADDR_W-1:0] A_ENC_IEN  = 12'h080;
  localparam logic [ADDR_W-1:0] A_ENC_STA  = 12'h084;
  localparam logic [ADDR_W-1:0] A_ENC_MAP  = 12'h088;
  localparam logic [ADDR_W-1:0] A_DEC_CTL  = 12'h100;
  localparam logic [ADDR_W-1:0] A_DEC_CFG  = 12'h104;
  localparam logic [ADDR_W-1:0] A_DEC_IDLE = 12'h10C;
  localparam logic [ADDR_W-1:0] A_DEC_MAP  = 12'h124;
  localparam logic [ADDR_W-1:0] A_DEC_IEN  = 12'h200;
  localparam logic [ADDR_W-1:0] A_DEC_STA  = 12'h204;

  typedef struct packed {
    logic wr_ctl;
    logic wr_cfg;
    logic wr_ien;
    logic rd_sta;
  } chan_acc_t;

  // strength list: even steps to 24, then steps of 4
  function automatic int unsigned strength_of(int unsigned idx, int unsigned num);
    if (idx >= num) return 0;
    if (idx < 11) return 4 + 2 * idx;
    return 28 + 4 * (idx - 11);
  endfunction

  function automatic int unsigned par_words(int unsigned str, int unsigned pbits);
    return (str * pbits + 31) / 32;
  endfunction
endpackage

// File: rtl/ecc_chan.sv
module ecc_chan
  import nand_ecc_pkg::*;
#(
  parameter int SECTORS  = 4,
  parameter int STEP_CYC = 8,
  parameter bit PAGE_IRQ = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  chan_acc_t          acc_i,
  input  logic [31:0]        wdata_i,
  output logic               ctl_o,
  output logic [31:0]        cfg_o,
  output logic [1:0]         ien_o,
  output logic               sta_o,
  output logic               idle_o,
  output logic [SECTORS-1:0] done_map_o
);
  localparam int CYC_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic             busy;
  logic [CYC_W-1:0] cyc;
  logic [SEC_W-1:0] sec;
  logic start, stop, step_end, last, page_mode, sta_set;

  assign start     = acc_i.wr_ctl && wdata_i[0];
  assign stop      = acc_i.wr_ctl && !wdata_i[0];
  assign step_end  = busy && (cyc == CYC_W'(STEP_CYC - 1));
  assign last      = (sec == SEC_W'(SECTORS - 1));
  assign page_mode = PAGE_IRQ && ien_o[1];
  assign sta_set   = step_end && (!page_mode || last);
  assign idle_o    = !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o      <= 1'b0;
      cfg_o      <= '0;
      ien_o      <= '0;
      sta_o      <= 1'b0;
      busy       <= 1'b0;
      cyc        <= '0;
      sec        <= '0;
      done_map_o <= '0;
    end else begin
      if (acc_i.wr_ctl) ctl_o <= wdata_i[0];
      if (acc_i.wr_cfg && !busy) cfg_o <= wdata_i;
      if (acc_i.wr_ien) ien_o <= wdata_i[1:0];
      if (start) begin
        busy       <= 1'b1;
        cyc        <= '0;
        sec        <= '0;
        done_map_o <= '0;
        sta_o      <= 1'b0;
      end else if (stop) begin
        busy  <= 1'b0;
        sta_o <= 1'b0;
      end else begin
        if (step_end) begin
          cyc             <= '0;
          done_map_o[sec] <= 1'b1;
          if (last) busy <= 1'b0;
          else      sec  <= sec + 1'b1;
        end else if (busy) begin
          cyc <= cyc + 1'b1;
        end
        // set beats a same-cycle read clear
        if (sta_set)           sta_o <= 1'b1;
        else if (acc_i.rd_sta) sta_o <= 1'b0;
      end
    end
  end

  // R3
  map_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !start) |=> ((done_map_o & $past(done_map_o)) == $past(done_map_o)));
  // R7
  map_frozen_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start) |=> $stable(done_map_o));
  // R2
  page_end_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !$past(stop)) |-> done_map_o[SECTORS-1]);
  // R5
  page_irq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sta_o) && $past(page_mode)) |-> (&done_map_o));
endmodule

// File: rtl/ecc_par_win.sv
module ecc_par_win
  import nand_ecc_pkg::*;
#(
  parameter int          PAR_WORDS = 27,
  parameter int          PAR_BITS  = 14,
  parameter int          NUM_STR   = 20,
  parameter logic [31:0] PAR_SEED  = 32'hC3A5_5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              last_done_i,
  input  logic [4:0]        str_idx_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [31:0]       data_o
);
  localparam int VW_W = $clog2(PAR_WORDS + 1);

  logic [VW_W-1:0]   vld;
  logic              last_q;
  logic [ADDR_W-3:0] word;
  int unsigned       new_w;

  assign word  = off_i[ADDR_W-1:2];
  assign new_w = par_words(strength_of(32'(str_idx_i), NUM_STR), PAR_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld    <= '0;
      last_q <= 1'b0;
    end else begin
      last_q <= last_done_i;
      if (clr_i)
        vld <= '0;
      else if (last_done_i && !last_q)
        vld <= (new_w > PAR_WORDS) ? VW_W'(PAR_WORDS) : VW_W'(new_w);
    end
  end

  always_comb begin
    data_o = '0;
    if (sel_i && (off_i[1:0] == 2'b00) && (32'(word) < 32'(vld)))
      data_o = PAR_SEED ^ {4{word[7:0]}};
  end

  // R9
  par_len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(vld) <= PAR_WORDS);
endmodule

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
  import nand_ecc_pkg::*;
#(
  parameter int          SECTORS  = 4,
  parameter int          STEP_CYC = 8,
  parameter int          NUM_STR  = 20,
  parameter int          PAR_BITS = 14,
  parameter bit          PAGE_IRQ = 1'b1,
  parameter logic [31:0] PAR_SEED = 32'hC3A5_5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int PAR_WORDS = par_words(strength_of(NUM_STR - 1, NUM_STR), PAR_BITS);
  localparam logic [ADDR_W-1:0] PAR_END = A_PAR_BASE + ADDR_W'(4 * PAR_WORDS);

  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  chan_acc_t          acc    [2];
  logic [1:0]         ctl_v, sta_v, idle_v;
  logic [31:0]        cfg_v  [2];
  logic [1:0]         ien_v  [2];
  logic [SECTORS-1:0] done_v [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTL_A = (c == 0) ? A_ENC_CTL : A_DEC_CTL;
    localparam logic [ADDR_W-1:0] CFG_A = (c == 0) ? A_ENC_CFG : A_DEC_CFG;
    localparam logic [ADDR_W-1:0] IEN_A = (c == 0) ? A_ENC_IEN : A_DEC_IEN;
    localparam logic [ADDR_W-1:0] STA_A = (c == 0) ? A_ENC_STA : A_DEC_STA;

    assign acc[c].wr_ctl = wr && (addr_i == CTL_A);
    assign acc[c].wr_cfg = wr && (addr_i == CFG_A);
    assign acc[c].wr_ien = wr && (addr_i == IEN_A);
    assign acc[c].rd_sta = rd && (addr_i == STA_A);

    ecc_chan #(
      .SECTORS (SECTORS),
      .STEP_CYC(STEP_CYC),
      .PAGE_IRQ(PAGE_IRQ)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_i     (acc[c]),
      .wdata_i   (wdata_i),
      .ctl_o     (ctl_v[c]),
      .cfg_o     (cfg_v[c]),
      .ien_o     (ien_v[c]),
      .sta_o     (sta_v[c]),
      .idle_o    (idle_v[c]),
      .done_map_o(done_v[c])
    );
  end

  logic        par_sel;
  logic [31:0] par_data;
  assign par_sel = (addr_i >= A_PAR_BASE) && (addr_i < PAR_END);

  ecc_par_win #(
    .PAR_WORDS(PAR_WORDS),
    .PAR_BITS (PAR_BITS),
    .NUM_STR  (NUM_STR),
    .PAR_SEED (PAR_SEED)
  ) u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (acc[0].wr_ctl && wdata_i[0]),
    .last_done_i(done_v[0][SECTORS-1]),
    .str_idx_i  (cfg_v[0][4:0]),
    .sel_i      (par_sel),
    .off_i      (addr_i - A_PAR_BASE),
    .data_o     (par_data)
  );

  always_comb begin
    rdata_o = par_sel ? par_data : '0;
    unique case (addr_i)
      A_ENC_CTL:  rdata_o = {31'b0, ctl_v[0]};
      A_ENC_CFG:  rdata_o = cfg_v[0];
      A_ENC_IDLE: rdata_o = {31'b0, idle_v[0]};
      A_ENC_IEN:  rdata_o = {30'b0, ien_v[0]};
      A_ENC_STA:  rdata_o = {31'b0, sta_v[0]};
      A_ENC_MAP:  rdata_o = 32'(done_v[0]);
      A_DEC_CTL:  rdata_o = {31'b0, ctl_v[1]};
      A_DEC_CFG:  rdata_o = cfg_v[1];
      A_DEC_IDLE: rdata_o = {31'b0, idle_v[1]};
      A_DEC_IEN:  rdata_o = {30'b0, ien_v[1]};
      A_DEC_STA:  rdata_o = {31'b0, sta_v[1]};
      A_DEC_MAP:  rdata_o = 32'(done_v[1]);
      default: ;
    endcase
    if (!rd) rdata_o = '0;
  end

  assign irq_o = (sta_v[0] && ien_v[0][0]) || (sta_v[1] && ien_v[1][0]);
endmodule

// File: tb/tb_nand_ecc_regs.sv
module tb_nand_ecc_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] SEED       = 32'hC3A5_5A3C;
  localparam int          NT         = 6;
  localparam int          TBL_IDX [NT] = '{0, 5, 10, 11, 19, 20};
  localparam int          TBL_W   [NT] = '{2, 7, 11, 13, 27, 0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_ecc_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle(input logic [11:0] a);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(a, v);
      if (v[0]) break;
    end
  endtask

  task automatic wait_map(input logic [11:0] a);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(a, v);
      if (v != 0) break;
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b = 8'(i);
    return SEED ^ {4{b}};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h000, v); chk("R1 enc ctl", v, 0);
    rd(12'h00C, v); chk("R1 enc idle", v, 1);
    rd(12'h10C, v); chk("R1 dec idle", v, 1);
    rd(12'h104, v); chk("R1 dec cfg", v, 0);
    rd(12'h204, v); chk("R1 dec sta", v, 0);
    rd(12'h124, v); chk("R1 dec map", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R9 table walk: strength index -> valid parity words
    for (int t = 0; t < NT; t++) begin
      wr(12'h004, 32'(TBL_IDX[t]) | 32'h0020_0000);
      wr(12'h000, 1);
      rd(12'h010, v); chk("R9 cleared on start", v, 0);
      wait_idle(12'h00C);
      if (TBL_W[t] > 0) begin
        rd(12'h010 + 12'(4 * (TBL_W[t] - 1)), v);
        chk("R9 last valid word", v, pat(TBL_W[t] - 1));
      end
      if (TBL_W[t] < 27) begin
        rd(12'h010 + 12'(4 * TBL_W[t]), v);
        chk("R9 first invalid word", v, 0);
      end
      wr(12'h000, 0);
    end
    rd(12'h014, v); chk("R9 word1 kept after stop", v, 0);
    rd(12'h088, v); chk("R3 enc map full", v, 32'hF);

    // R8 config readback, busy write ignored; R2 idle while running
    wr(12'h104, 32'h8123_3005);
    rd(12'h104, v); chk("R8 dec cfg readback", v, 32'h8123_3005);
    wr(12'h100, 1);
    rd(12'h10C, v); chk("R2 dec busy", v, 0);
    wr(12'h104, 32'h0000_0001);
    rd(12'h104, v); chk("R8 busy write ignored", v, 32'h8123_3005);
    wait_idle(12'h10C);
    rd(12'h10C, v); chk("R2 dec idle after page", v, 1);
    rd(12'h124, v); chk("R3 dec map full", v, 32'hF);
    chk("R6 irq off when disabled", 32'(irq), 0);
    rd(12'h204, v); chk("R4 sta set", v, 1);
    rd(12'h204, v); chk("R4 sta read-clear", v, 0);

    // R4/R6 per-step interrupt mid-page
    wr(12'h100, 0);
    wr(12'h200, 1);
    wr(12'h100, 1);
    rd(12'h124, v); chk("R3 map cleared on start", v, 0);
    wait_map(12'h124);
    rd(12'h124, v); chk("R3 first sector only", v, 1);
    chk("R6 irq per step", 32'(irq), 1);
    rd(12'h204, v); chk("R4 step sta", v, 1);
    chk("R4 irq drops after read", 32'(irq), 0);
    wait_idle(12'h10C);

    // R5 per-page interrupt
    wr(12'h100, 0);
    wr(12'h200, 3);
    wr(12'h100, 1);
    wait_map(12'h124);
    chk("R5 no irq mid-page", 32'(irq), 0);
    rd(12'h204, v); chk("R5 no sta mid-page", v, 0);
    wait_idle(12'h10C);
    chk("R5 irq at page end", 32'(irq), 1);
    rd(12'h204, v); chk("R5 sta at page end", v, 1);

    // R7 stop mid-run
    wr(12'h100, 0);
    wr(12'h200, 1);
    wr(12'h100, 1);
    wait_map(12'h124);
    wr(12'h100, 0);
    rd(12'h10C, v); chk("R7 idle after stop", v, 1);
    chk("R7 irq cleared by stop", 32'(irq), 0);
    rd(12'h204, v); chk("R7 sta cleared by stop", v, 0);
    rd(12'h124, v);
    repeat (40) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(12'h124, v2); chk("R7 map frozen", v2, v);
      chk("R7 map partial", 32'(v2 != 32'hF), 1);
    end

    // R10 unmapped
    rd(12'h300, v); chk("R10 unmapped", v, 0);
    rd(12'h08C, v); chk("R10 gap", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule